// File: doc/BRIEF.md
# Local Interrupt Acceptance Core

This block is the per-processor end of an interrupt delivery path. It accepts requests for 256 vectors, holds them in a pending array and tracks which vectors the processor is servicing in an in-service array. A third array records, per vector, whether the last accepted request was level- or edge-triggered. Requests that name an out-of-range vector, or that repeat a vector already pending, are dropped and leave a sticky flag in an error word.

The core compares the highest pending vector against the highest in-service vector to decide whether to assert its request line to the processor. On an acknowledge it hands over the highest pending vector and moves it from pending to in-service. An end-of-interrupt strobe retires the highest in-service vector. A programmable task priority, combined with the class (upper nibble) of the highest in-service vector, yields the processor priority. A one-shot bypass flag lets the next request skip the duplicate check, which external-interrupt delivery needs. All three arrays and the error word can be read as 32-bit words through a small address-decoded read port.

Top module: `lic_core`

## Requirements
- R1: A request whose vector exceeds LAST_LEGAL (default 0xFE) changes no array and sets error bit 6 (illegal vector); error bits stay set until reset.
- R2: A legal request whose pending bit is already set, with the bypass flag clear, is dropped: pending and trigger-mode arrays keep their values and error bit 3 (accept error) is set.
- R3: While the bypass flag is set, the next legal request is accepted even if its pending bit is set, and the flag is then cleared; the request after it is checked for duplicates again.
- R4: An accepted request sets its pending bit and writes its trigger-mode bit: 1 for level-triggered (trig_level=1), 0 for edge-triggered.
- R5: The processor priority equals the task priority when task priority bits 7:4 are greater than or equal to the class (bits 7:4) of the highest in-service vector, or when nothing is in service; otherwise it equals that class in bits 7:4 with bits 3:0 zero.
- R6: irq_out is high only when some vector is pending and the highest pending vector is numerically greater than the highest in-service vector (or nothing is in service).
- R7: An acknowledge while irq_out is high returns the highest pending vector on ack_vector, and in the next cycle that vector's pending bit is clear and its in-service bit set; an acknowledge while irq_out is low changes nothing.
- R8: Reads return, with bit j of word k standing for vector 32*k+j: in-service word k at 0x100+16*k, trigger-mode word k at 0x180+16*k, pending word k at 0x200+16*k, and the error word in bits 7:0 at 0x280; address bits 3:0 are ignored and every other address reads zero.
- R9: An end-of-interrupt strobe clears the highest set in-service bit, with irq_out and the processor priority reflecting it in the next cycle; with nothing in service it has no effect.
- R10: After reset all three arrays, the task priority, the error word and the bypass flag are zero, so irq_out is low and the processor priority is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Incoming interrupt request strobe |
| trig_vector | input | 8 | Vector of the incoming request |
| trig_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| bypass_set | input | 1 | Arms the one-shot duplicate-check bypass |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Processor acknowledge strobe |
| ack_vector | output | 8 | Highest pending vector, valid while irq_out is high |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority write value |
| ppr | output | 8 | Processor priority |
| rd_addr | input | 12 | Status read byte address |
| rd_data | output | 32 | Status read data |

## Verification
The bench builds the core with its default parameters: 256 vectors, the top legal vector at 0xFE and the error flags at bits 6 and 3. These values put the last legal vector and the first illegal one side by side, so the boundary of R1 is exercised from both sides, and they make every word of the three 8-word arrays addressable, including the top word where vector 0xFE lands. The scenario moves vectors in several priority classes through pending, in-service and retirement, so both branches of the processor priority rule and the withheld-request case appear with the same task priority.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int LIC_NVEC   = 256;
    localparam int LIC_VEC_W  = $clog2(LIC_NVEC);
    localparam int LIC_PRI_W  = 8;
    localparam int LIC_CLS_W  = 4;
    localparam int LIC_BUS_W  = 32;
    localparam int LIC_ADDR_W = 12;
    localparam int LIC_ESR_W  = 8;
    localparam int LIC_WORDS  = LIC_NVEC / LIC_BUS_W;

    typedef struct packed {
        logic [LIC_NVEC-1:0]  pend;
        logic [LIC_NVEC-1:0]  insvc;
        logic [LIC_NVEC-1:0]  tmode;
        logic [LIC_PRI_W-1:0] tpr;
        logic [LIC_ESR_W-1:0] esr;
        logic                 bypass;
    } lic_state_t;

endpackage

// File: rtl/lic_prio_enc.sv
module lic_prio_enc #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic [IW-1:0] idx,
    output logic          found
);

    // Highest set bit wins: later iterations overwrite earlier ones.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lic_ppr_calc.sv
module lic_ppr_calc #(
    parameter int PRI_W = 8,
    parameter int CLS_W = 4,
    parameter int VEC_W = 8
) (
    input  logic [PRI_W-1:0] tpr,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             isr_found,
    output logic [PRI_W-1:0] ppr
);

    logic [CLS_W-1:0] isr_cls;
    logic [CLS_W-1:0] tpr_cls;

    always_comb begin
        isr_cls = isr_found ? isr_top[VEC_W-1 -: CLS_W] : '0;
        tpr_cls = tpr[PRI_W-1 -: CLS_W];
        if (tpr_cls >= isr_cls)
            ppr = tpr;
        else
            ppr = {isr_cls, {(PRI_W-CLS_W){1'b0}}};
    end

endmodule

// File: rtl/lic_status_mux.sv
module lic_status_mux #(
    parameter int          NVEC     = 256,
    parameter int          BUS_W    = 32,
    parameter int          ADDR_W   = 12,
    parameter int          ESR_W    = 8,
    parameter int unsigned ISR_BASE = 32'h100,
    parameter int unsigned TMR_BASE = 32'h180,
    parameter int unsigned IRR_BASE = 32'h200,
    parameter int unsigned ESR_ADDR = 32'h280
) (
    input  logic [NVEC-1:0]   insvc,
    input  logic [NVEC-1:0]   tmode,
    input  logic [NVEC-1:0]   pend,
    input  logic [ESR_W-1:0]  esr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data
);

    localparam int unsigned WORDS = NVEC / BUS_W;
    localparam int unsigned SPAN  = WORDS * 16;

    function automatic logic [BUS_W-1:0] word_of(input logic [NVEC-1:0] arr,
                                                  input int unsigned   w);
        word_of = arr[w*BUS_W +: BUS_W];
    endfunction

    int unsigned a;

    always_comb begin
        a       = 32'(rd_addr);
        rd_data = '0;
        if (a >= ISR_BASE && a < ISR_BASE + SPAN)
            rd_data = word_of(insvc, (a - ISR_BASE) / 16);
        else if (a >= TMR_BASE && a < TMR_BASE + SPAN)
            rd_data = word_of(tmode, (a - TMR_BASE) / 16);
        else if (a >= IRR_BASE && a < IRR_BASE + SPAN)
            rd_data = word_of(pend, (a - IRR_BASE) / 16);
        else if ((a / 16) == (ESR_ADDR / 16))
            rd_data = BUS_W'(esr);
    end

endmodule

// File: rtl/lic_core.sv
module lic_core
    import lic_pkg::*;
#(
    parameter int unsigned LAST_LEGAL  = 32'hFE,
    parameter int          ILL_ERR_BIT = 6,
    parameter int          ACC_ERR_BIT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_valid,
    input  logic [LIC_VEC_W-1:0]  trig_vector,
    input  logic                  trig_level,
    input  logic                  bypass_set,
    output logic                  irq_out,
    input  logic                  ack,
    output logic [LIC_VEC_W-1:0]  ack_vector,
    input  logic                  eoi,
    input  logic                  tpr_we,
    input  logic [LIC_PRI_W-1:0]  tpr_wdata,
    output logic [LIC_PRI_W-1:0]  ppr,
    input  logic [LIC_ADDR_W-1:0] rd_addr,
    output logic [LIC_BUS_W-1:0]  rd_data
);

    lic_state_t state_q, state_d;

    logic [LIC_VEC_W-1:0] pend_top, isr_top;
    logic                 pend_found, isr_found;
    logic                 ack_fire;
    logic                 vec_legal;

    lic_prio_enc #(.W(LIC_NVEC), .IW(LIC_VEC_W)) u_pend_enc (
        .bits  (state_q.pend),
        .idx   (pend_top),
        .found (pend_found)
    );

    lic_prio_enc #(.W(LIC_NVEC), .IW(LIC_VEC_W)) u_isr_enc (
        .bits  (state_q.insvc),
        .idx   (isr_top),
        .found (isr_found)
    );

    lic_ppr_calc #(.PRI_W(LIC_PRI_W), .CLS_W(LIC_CLS_W), .VEC_W(LIC_VEC_W)) u_ppr (
        .tpr       (state_q.tpr),
        .isr_top   (isr_top),
        .isr_found (isr_found),
        .ppr       (ppr)
    );

    lic_status_mux #(
        .NVEC   (LIC_NVEC),
        .BUS_W  (LIC_BUS_W),
        .ADDR_W (LIC_ADDR_W),
        .ESR_W  (LIC_ESR_W)
    ) u_rd (
        .insvc   (state_q.insvc),
        .tmode   (state_q.tmode),
        .pend    (state_q.pend),
        .esr     (state_q.esr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Request only when the top pending vector outranks the top in-service one.
    assign irq_out    = pend_found && (!isr_found || (pend_top > isr_top));
    assign ack_vector = pend_top;
    assign ack_fire   = ack && irq_out;
    assign vec_legal  = 32'(trig_vector) <= LAST_LEGAL;

    always_comb begin
        state_d = state_q;

        // Retire the top in-service vector.
        if (eoi && isr_found)
            state_d.insvc[isr_top] = 1'b0;

        // Hand the top pending vector to the processor.
        if (ack_fire) begin
            state_d.pend[pend_top]  = 1'b0;
            state_d.insvc[pend_top] = 1'b1;
        end

        if (tpr_we)
            state_d.tpr = tpr_wdata;

        // Incoming request: range check, then duplicate check against
        // the registered pending array unless the bypass is armed.
        if (trig_valid) begin
            if (!vec_legal) begin
                state_d.esr[ILL_ERR_BIT] = 1'b1;
            end else if (state_q.pend[trig_vector] && !state_q.bypass) begin
                state_d.esr[ACC_ERR_BIT] = 1'b1;
            end else begin
                state_d.pend[trig_vector]  = 1'b1;
                state_d.tmode[trig_vector] = trig_level;
                state_d.bypass             = 1'b0;
            end
        end

        if (bypass_set)
            state_d.bypass = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    AST_ILLEGAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && !vec_legal && !ack_fire)
        |=> ($stable(state_q.pend) && state_q.esr[ILL_ERR_BIT])); // R1

    AST_DUP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && vec_legal && state_q.pend[trig_vector] && !state_q.bypass)
        |=> (state_q.esr[ACC_ERR_BIT]
             && state_q.tmode[$past(trig_vector)] == $past(state_q.tmode[trig_vector]))); // R2

    AST_BYPASS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && vec_legal && state_q.bypass && !bypass_set)
        |=> !state_q.bypass); // R3

    AST_ACCEPT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && vec_legal && (!state_q.pend[trig_vector] || state_q.bypass))
        |=> (state_q.pend[$past(trig_vector)]
             && state_q.tmode[$past(trig_vector)] == $past(trig_level))); // R4

    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= state_q.tpr); // R5

    AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pend == '0) |-> !irq_out); // R6

    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> (state_q.insvc[$past(ack_vector)] && !state_q.pend[$past(ack_vector)]
                      || ($past(trig_valid) && $past(trig_vector) == $past(ack_vector)))); // R7

    AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr_found && !ack_fire) |=> !state_q.insvc[$past(isr_top)]); // R9

endmodule

// File: tb/lic_core_test.sv
module lic_core_test;
    import lic_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  trig_valid = 1'b0;
    logic [LIC_VEC_W-1:0]  trig_vector = '0;
    logic                  trig_level = 1'b0;
    logic                  bypass_set = 1'b0;
    logic                  irq_out;
    logic                  ack = 1'b0;
    logic [LIC_VEC_W-1:0]  ack_vector;
    logic                  eoi = 1'b0;
    logic                  tpr_we = 1'b0;
    logic [LIC_PRI_W-1:0]  tpr_wdata = '0;
    logic [LIC_PRI_W-1:0]  ppr;
    logic [LIC_ADDR_W-1:0] rd_addr = '0;
    logic [LIC_BUS_W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] vec;
        string      req;
    } exp_t;
    exp_t sb[$];

    lic_core uut (
        .clk, .rst_n, .trig_valid, .trig_vector, .trig_level, .bypass_set,
        .irq_out, .ack, .ack_vector, .eoi, .tpr_we, .tpr_wdata, .ppr,
        .rd_addr, .rd_data
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: each effective acknowledge pops the scoreboard.
    always @(posedge clk) begin
        if (rst_n && ack && irq_out) begin
            if (sb.size() == 0) begin
                chk("R7 unexpected acknowledge", {24'b0, ack_vector}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, {24'b0, ack_vector}, {24'b0, e.vec});
            end
        end
    end

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic now(input string req, input logic [31:0] act, input logic [31:0] exp);
        #1;
        chk(req, act, exp);
    endtask

    task automatic trig(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        trig_valid = 1'b1; trig_vector = v; trig_level = lvl;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] v, input string req);
        exp_t e;
        e.vec = v; e.req = req;
        sb.push_back(e);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic stray_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
    endtask

    task automatic set_tpr(input logic [7:0] v);
        @(negedge clk); tpr_we = 1'b1; tpr_wdata = v;
        @(negedge clk); tpr_we = 1'b0;
    endtask

    task automatic arm_bypass();
        @(negedge clk); bypass_set = 1'b1;
        @(negedge clk); bypass_set = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        now("R10 irq after reset", {31'b0, irq_out}, 32'h0);
        now("R10 ppr after reset", {24'b0, ppr}, 32'h0);
        rd("R10 pending word0 after reset", 12'h200, 32'h0);
        rd("R10 error word after reset", 12'h280, 32'h0);

        // R4 edge accept of 0x31 (word 1 bit 17)
        trig(8'h31, 1'b0);
        rd("R4 pending 0x31", 12'h210, 32'h0002_0000);
        rd("R4 edge trigger-mode 0x31", 12'h190, 32'h0);
        now("R6 irq with pending only", {31'b0, irq_out}, 32'h1);
        now("R7 ack_vector shows top pending", {24'b0, ack_vector}, 32'h31);

        // R4 level accept of 0x45 (word 2 bit 5)
        trig(8'h45, 1'b1);
        rd("R4 pending 0x45", 12'h220, 32'h20);
        rd("R4 level trigger-mode 0x45", 12'h1A0, 32'h20);

        // R2 duplicate (edge) must not touch trigger mode
        trig(8'h45, 1'b0);
        rd("R2 accept error flag", 12'h280, 32'h08);
        rd("R2 trigger mode unchanged", 12'h1A0, 32'h20);

        // R1 illegal vector
        trig(8'hFF, 1'b1);
        rd("R1 illegal flag", 12'h280, 32'h48);
        rd("R1 no pending in top word", 12'h270, 32'h0);
        rd("R1 no trigger mode in top word", 12'h1F0, 32'h0);

        // R7 acknowledge moves 0x45 to in-service
        do_ack(8'h45, "R7 ack returns 0x45");
        rd("R7 pending 0x45 cleared", 12'h220, 32'h0);
        rd("R7 in-service 0x45 set", 12'h120, 32'h20);
        now("R6 withheld below in-service", {31'b0, irq_out}, 32'h0);
        now("R5 ppr from in-service class", {24'b0, ppr}, 32'h40);

        // R7 acknowledge while irq low is ignored
        stray_ack();
        rd("R7 stray ack in-service word1", 12'h110, 32'h0);
        rd("R7 stray ack pending word1", 12'h210, 32'h0002_0000);

        // R5 both branches
        set_tpr(8'h5A);
        now("R5 ppr equals task priority", {24'b0, ppr}, 32'h5A);
        set_tpr(8'h3A);
        now("R5 ppr from class when task lower", {24'b0, ppr}, 32'h40);

        // R9 end of interrupt
        do_eoi();
        rd("R9 in-service 0x45 retired", 12'h120, 32'h0);
        now("R9 irq re-raised", {31'b0, irq_out}, 32'h1);
        now("R9 ppr back to task priority", {24'b0, ppr}, 32'h3A);

        do_ack(8'h31, "R7 ack returns 0x31");
        rd("R7 in-service 0x31 set", 12'h110, 32'h0002_0000);
        now("R5 equal class keeps task priority", {24'b0, ppr}, 32'h3A);
        now("R6 nothing pending", {31'b0, irq_out}, 32'h0);

        // R3 bypass one-shot on 0x80 (word 4 bit 0)
        trig(8'h80, 1'b0);
        rd("R4 pending 0x80", 12'h240, 32'h1);
        rd("R4 edge trigger-mode 0x80", 12'h1C0, 32'h0);
        now("R6 irq above in-service", {31'b0, irq_out}, 32'h1);
        arm_bypass();
        trig(8'h80, 1'b1);
        rd("R3 bypass accepted duplicate", 12'h1C0, 32'h1);
        trig(8'h80, 1'b0);
        rd("R3 bypass consumed, duplicate dropped", 12'h1C0, 32'h1);

        // R1 boundary: 0xFE is legal (word 7 bit 30)
        trig(8'hFE, 1'b1);
        rd("R1 top legal vector pending", 12'h270, 32'h4000_0000);
        rd("R8 address low bits ignored", 12'h27C, 32'h4000_0000);
        do_ack(8'hFE, "R7 ack returns 0xFE");
        rd("R8 in-service top word", 12'h170, 32'h4000_0000);
        now("R5 ppr from class 0xF", {24'b0, ppr}, 32'hF0);
        rd("R8 unmapped address", 12'h300, 32'h0);

        do_eoi();
        rd("R9 0xFE retired", 12'h170, 32'h0);
        rd("R9 0x31 still in service", 12'h110, 32'h0002_0000);
        now("R9 ppr after second retire", {24'b0, ppr}, 32'h3A);

        @(negedge clk);
        chk("R7 scoreboard drained", sb.size(), 32'h0);
        finish_run();
    end

endmodule